// File: doc/BRIEF.md
# Multi-Read-Port Register File with Write Bypass

This block is a register file with a single write port and a configurable number of independent read ports. It gets its read ports by instantiating one synchronous two-port memory copy per read port. All copies take the same write address, write data and write enable on their first port, so their contents never diverge. The second port of each copy serves one read address.

Reads are synchronous. An address presented with its read enable high at a rising edge produces data that is valid after that edge. The memory copies follow read-first behaviour, so a read that hits the location being written in the same edge would return stale contents. A registered address comparison and a registered copy of the write data replace that value with the new data. The forwarded value appears in the same cycle as an ordinary read.

The synchronous reset clears only the read-side output registers of ports whose read enable is high. It never alters stored contents, and it blocks writes while it is asserted.

Top module: `mrf_regfile`

## Requirements
- R1: A read is registered. With `rd_en[i]`=1 and `rst`=0 at a rising edge, `rd_data` slice i shows the word stored at `rd_addr` slice i after that edge. Changing the address between edges does not alter the output.
- R2: A write stores `wr_data` at `wr_addr` on a rising edge where `wr_en`=1 and `rst`=0. Every read port then sees the same stored word, and two ports reading the same address in the same cycle return equal data.
- R3: All read ports work independently. In one cycle each port may read a different address and receives that address's word.
- R4: When a port reads the address being written at the same edge, its output after that edge is the new `wr_data`, not the previous contents.
- R5: A port with `rd_en[i]`=0 holds its previous output, even if its address matches a write.
- R6: At an edge with `rst`=1, every port with `rd_en[i]`=1 has its output cleared to zero. Ports with `rd_en[i]`=0 hold their output.
- R7: Reset leaves stored contents unchanged, and a write request with `rst`=1 is ignored.
- R8: A word written at one edge is returned by a read of that address at the next edge.
- Packing: read port i uses `rd_addr[i*AW +: AW]` and `rd_data[i*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of enabled read outputs |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | NRD | Per-port read enable |
| rd_addr | input | NRD*AW | Packed read addresses |
| rd_data | output | NRD*DW | Packed read data |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it: read data, forwarded write data, the reset clear, and a held value all appear after that edge. A write becomes visible to a read issued at the following edge. The bench drives each stimulus on a falling edge and samples one full cycle later, on the next falling edge, after a single rising edge has passed. It predicts every port from an array model updated only after that cycle's expectations are formed, so same-edge collisions expect the new word and all other reads expect the previous contents.

// File: rtl/mrf_pkg.sv
package mrf_pkg;
  // Registered bypass decision: a live write whose address matches a read.
  function automatic logic addr_hit(input logic we, input logic [31:0] wa,
                                    input logic [31:0] ra);
    return we && (wa == ra);
  endfunction
endpackage

// File: rtl/mrf_dpram.sv
module mrf_dpram #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_din,
  input  logic          b_en,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_dout
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // write port: blocked during reset
  always_ff @(posedge clk) begin
    if (a_we && !rst) mem[a_addr] <= a_din;
  end

  // read port: read-first, output register cleared by reset when enabled
  always_ff @(posedge clk) begin
    if (b_en) begin
      if (rst) b_dout <= '0;
      else     b_dout <= mem[b_addr];
    end
  end
endmodule

// File: rtl/mrf_bypass.sv
module mrf_bypass
  import mrf_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] mem_dout,
  output logic [DW-1:0] dout
);
  logic          hit_q;
  logic [DW-1:0] fwd_q;
  logic          clr_q;

  always_ff @(posedge clk) begin
    if (en) begin
      if (rst) begin
        hit_q <= 1'b0;
      end else begin
        hit_q <= addr_hit(wr_en, 32'(wr_addr), 32'(rd_addr));
        fwd_q <= wr_data;
      end
    end
  end

  assign dout = hit_q ? fwd_q : mem_dout;

  // reset observation flag for the clear check
  always_ff @(posedge clk) clr_q <= en && rst;

  // R6
  always_comb begin
    if (clr_q) begin
      rst_clear_chk: assert (dout == '0);
    end
  end

  // R4
  bypass_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (en && wr_en && rd_addr == wr_addr) |=> dout == $past(wr_data));

  // R5
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout));
endmodule

// File: rtl/mrf_regfile.sv
module mrf_regfile #(
  parameter int NRD = 4,
  parameter int DW  = 16,
  parameter int AW  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NRD-1:0]    rd_en,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data
);
  for (genvar g = 0; g < NRD; g++) begin : g_port
    logic [DW-1:0] raw;

    mrf_dpram #(.DW(DW), .AW(AW)) u_copy (
      .clk    (clk),
      .rst    (rst),
      .a_we   (wr_en),
      .a_addr (wr_addr),
      .a_din  (wr_data),
      .b_en   (rd_en[g]),
      .b_addr (rd_addr[g*AW +: AW]),
      .b_dout (raw)
    );

    mrf_bypass #(.DW(DW), .AW(AW)) u_byp (
      .clk      (clk),
      .rst      (rst),
      .en       (rd_en[g]),
      .rd_addr  (rd_addr[g*AW +: AW]),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .mem_dout (raw),
      .dout     (rd_data[g*DW +: DW])
    );

    if (g > 0) begin : g_same
      // R2
      copies_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en[0] && rd_en[g] && rd_addr[0 +: AW] == rd_addr[g*AW +: AW])
        |=> rd_data[0 +: DW] == rd_data[g*DW +: DW]);
    end
  end
endmodule

// File: tb/mrf_regfile_test.sv
module mrf_regfile_test;
  localparam int N = 3;
  localparam int W = 8;
  localparam int A = 3;
  localparam int D = 1 << A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [A-1:0]  wr_addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [N-1:0]  rd_en = '0;
  logic [N*A-1:0] rd_addr = '0;
  logic [N*W-1:0] rd_data;

  int errs = 0;
  int checks = 0;
  logic [W-1:0] mdl [D];
  logic [W-1:0] prev [N];

  mrf_regfile #(.NRD(N), .DW(W), .AW(A)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [W-1:0] fillv(int a);
    return W'(a * 37 + 11);
  endfunction

  task automatic step(input string tag, input logic r, input logic we,
                      input logic [A-1:0] wa, input logic [W-1:0] wd,
                      input logic [N-1:0] re, input logic [A-1:0] ra0,
                      input logic [A-1:0] ra1, input logic [A-1:0] ra2);
    logic [A-1:0] ra [N];
    logic [W-1:0] exp [N];
    ra[0] = ra0; ra[1] = ra1; ra[2] = ra2;
    for (int i = 0; i < N; i++) begin
      if (!re[i])                 exp[i] = prev[i];
      else if (r)                 exp[i] = '0;
      else if (we && ra[i] == wa) exp[i] = wd;
      else                        exp[i] = mdl[ra[i]];
    end
    rst = r; wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re;
    rd_addr = {ra2, ra1, ra0};
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      checks++;
      if (rd_data[i*W +: W] !== exp[i]) begin
        errs++;
        $display("FAIL %s port %0d: got %h expected %h", tag, i,
                 rd_data[i*W +: W], exp[i]);
      end
      prev[i] = exp[i];
    end
    if (we && !r) mdl[wa] = wd;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mdl[i] = '0;
    for (int i = 0; i < N; i++) prev[i] = '0;
    @(negedge clk);
    // R6 reset clears enabled outputs; R7 write during reset ignored
    step("R6/R7 reset", 1'b1, 1'b1, 3'd0, 8'h55, 3'b111, 3'd0, 3'd0, 3'd0);
    // fill with reads disabled: outputs hold (R5)
    for (int a = 0; a < D; a++)
      step("R5 hold during fill", 1'b0, 1'b1, A'(a), fillv(a), 3'b000,
           A'(a), A'(a), A'(a));
    // R1/R3 independent registered reads on every rotation
    for (int a = 0; a < D; a++)
      step("R1/R3 sweep", 1'b0, 1'b0, '0, '0, 3'b111,
           A'(a), A'(a + 3), A'(a + 5));
    // R2 all ports same address agree
    for (int a = 0; a < D; a++)
      step("R2 same address", 1'b0, 1'b0, '0, '0, 3'b111, A'(a), A'(a), A'(a));
    // R6 reset with port 1 idle: it holds; R7 contents survive
    step("R6 partial reset", 1'b1, 1'b0, '0, '0, 3'b101, 3'd1, 3'd2, 3'd3);
    for (int a = 0; a < D; a++)
      step("R7 contents after reset", 1'b0, 1'b0, '0, '0, 3'b111,
           A'(a), A'(a + 1), A'(a + 2));
    // R4 collisions: ports 0 and 2 hit, port 1 reads neighbour
    for (int a = 0; a < D; a++)
      step("R4 bypass", 1'b0, 1'b1, A'(a), ~fillv(a) ^ W'(a), 3'b111,
           A'(a), A'(a + 1), A'(a));
    // R5 idle port ignores matching write
    step("R5 idle on hit", 1'b0, 1'b1, 3'd3, 8'hA5, 3'b011, 3'd3, 3'd4, 3'd3);
    // R8 read after write
    step("R8 read after write", 1'b0, 1'b0, '0, '0, 3'b111, 3'd3, 3'd3, 3'd3);
    step("R8 back to back", 1'b0, 1'b1, 3'd6, 8'h3C, 3'b000, 3'd0, 3'd0, 3'd0);
    step("R8 back to back", 1'b0, 1'b0, '0, '0, 3'b111, 3'd6, 3'd2, 3'd6);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule